// File: doc/BRIEF.md
# Serial Packet Transceiver With Odd Parity

This block turns 16-bit words into 17-bit serial frames and back. The send half accepts a word from the local logic, adds a parity bit chosen so that the frame holds an odd number of ones, and clocks the frame out one bit at a time on an open-drain slave data line. The receive half clocks bits in from the master data line, keeps the finished frame in a 17-bit holding register and reports whether its parity is correct.

Both halves move only on cycles where the link controller raises the shift enable, so the controller sets the bit rate and decides where frames begin. While it drives the shared line, the sender reads the line back. Any disagreement between the driven bit and the sensed bit means another module is pulling the wire. The sender then stops the frame, releases the line and raises a collision flag.

Top module: `serial_pkt_xcvr`

## Requirements
- R1: After reset, tx_busy, tx_done, tx_collision, rx_valid and rx_parity_err are 0, rx_word is 0 and tx_drive is 1 (line released).
- R2: A tx_load accepted while idle starts a frame. tx_drive presents data bit 15 first and continues down to bit 0, then presents the parity bit as the 17th bit. tx_drive is 1 whenever the sender is idle.
- R3: The generated parity bit makes the 17-bit frame contain an odd number of ones.
- R4: A bit position advances, in either direction, only at a clock edge where shift_en is 1. While shift_en is 0, tx_drive holds and the receiver samples nothing.
- R5: In the cycle after the edge that completes the 17th enabled bit, tx_busy is 0 and tx_done is 1. tx_done lasts exactly one cycle.
- R6: tx_load is ignored while tx_busy is 1. The frame in progress continues unchanged.
- R7: If tx_sense differs from tx_drive at an enabled edge, then after that edge tx_collision is 1, tx_busy is 0 and tx_drive is 1. tx_collision stays 1 until the next accepted tx_load clears it.
- R8: The receiver takes the first sampled bit as data bit 15 and the 17th as the parity bit. If the 17th bit is sampled at edge E, then after edge E+1 rx_word holds the data, rx_parity_err is valid and rx_valid is 1 for exactly one cycle.
- R9: rx_parity_err is 1 exactly when the 17 received bits hold an even number of ones.
- R10: Between frames, rx_word and rx_parity_err keep their values until the next frame completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| shift_en | input | 1 | Bit advance enable from the link controller |
| rx_din | input | 1 | Master data line, serial in |
| rx_word | output | 16 | Last received data word |
| rx_parity_err | output | 1 | Parity of the last received frame was even |
| rx_valid | output | 1 | One-cycle strobe when rx_word and rx_parity_err update |
| tx_load | input | 1 | Request to start sending tx_data |
| tx_data | input | 16 | Word to send |
| tx_drive | output | 1 | Value driven on the open-drain slave data line (1 = released) |
| tx_sense | input | 1 | Value read back from the slave data line |
| tx_busy | output | 1 | A frame is being sent |
| tx_done | output | 1 | One-cycle strobe when a frame finishes cleanly |
| tx_collision | output | 1 | The last frame was aborted on a line mismatch |

## Verification
A loaded word reaches tx_drive one edge after the load. Each later bit appears one edge after an enabled edge. The bench therefore counts enabled edges and compares tx_drive at every falling edge, so stalled cycles are checked as well. tx_done and a clean tx_busy are due one cycle after the 17th enabled edge. The receive strobe, word and parity flag are due one cycle after that, because the holding register adds a stage. A collision shows on the cycle after the mismatching edge. Every comparison is made at a falling edge, once all the registers on the path have settled.

// File: rtl/pkt_pkg.sv
package pkt_pkg;
    // default payload width of one packet
    localparam int PKT_W = 16;
    // level of a released open-drain line
    localparam logic LINE_IDLE = 1'b1;
endpackage

// File: rtl/pkt_rx.sv
module pkt_rx #(
    parameter int DATA_W = pkt_pkg::PKT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              shift_en,
    input  logic              din,
    output logic [DATA_W-1:0] word,
    output logic              parity_err,
    output logic              valid
);
    localparam int FRAME_W = DATA_W + 1;
    localparam int CW      = $clog2(DATA_W + 1);
    localparam logic [CW-1:0] LAST = CW'(DATA_W);

    typedef struct packed {
        logic [DATA_W-1:0]  sh;
        logic [CW-1:0]      cnt;
        logic               par;
        logic               pend;
        logic [FRAME_W-1:0] hold;
        logic               perr;
        logic               valid;
    } rx_st_t;

    rx_st_t rx_d, rx_q;

    always_comb begin
        rx_d       = rx_q;
        rx_d.valid = 1'b0;
        // capture stage: one edge after the parity bit was sampled
        if (rx_q.pend) begin
            rx_d.hold  = {rx_q.sh, rx_q.par};
            rx_d.perr  = ~^{rx_q.sh, rx_q.par};
            rx_d.valid = 1'b1;
            rx_d.pend  = 1'b0;
        end
        if (shift_en) begin
            if (rx_q.cnt == LAST) begin
                rx_d.par  = din;
                rx_d.pend = 1'b1;
                rx_d.cnt  = '0;
            end else begin
                rx_d.sh  = {rx_q.sh[DATA_W-2:0], din};
                rx_d.cnt = rx_q.cnt + CW'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rx_q <= '0;
        else        rx_q <= rx_d;
    end

    assign word       = rx_q.hold[FRAME_W-1:1];
    assign parity_err = rx_q.perr;
    assign valid      = rx_q.valid;

    assert_valid_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rx_q.valid |=> !rx_q.valid);
    assert_hold_steady_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rx_q.hold) |-> rx_q.valid);
    assert_no_sample_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !shift_en |=> $stable(rx_q.sh) && $stable(rx_q.cnt));
endmodule

// File: rtl/pkt_tx.sv
module pkt_tx #(
    parameter int DATA_W = pkt_pkg::PKT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              shift_en,
    input  logic              load,
    input  logic [DATA_W-1:0] data,
    input  logic              sense,
    output logic              drive,
    output logic              busy,
    output logic              done,
    output logic              collision
);
    localparam int FRAME_W = DATA_W + 1;
    localparam int CW      = $clog2(DATA_W + 1);
    localparam logic [CW-1:0] LAST = CW'(DATA_W);

    typedef struct packed {
        logic [DATA_W-1:0]  sh;
        logic [CW-1:0]      cnt;
        logic [FRAME_W-1:0] hold;
        logic               busy;
        logic               coll;
        logic               done;
    } tx_st_t;

    tx_st_t tx_d, tx_q;
    logic   bit_out;

    // parity bit sits in hold[0] and is sent after the last data bit
    assign bit_out = (tx_q.cnt == LAST) ? tx_q.hold[0] : tx_q.sh[DATA_W-1];
    assign drive   = tx_q.busy ? bit_out : pkt_pkg::LINE_IDLE;

    always_comb begin
        tx_d      = tx_q;
        tx_d.done = 1'b0;
        if (!tx_q.busy) begin
            if (load) begin
                tx_d.sh   = data;
                tx_d.hold = {data, ~^data};
                tx_d.cnt  = '0;
                tx_d.busy = 1'b1;
                tx_d.coll = 1'b0;
            end
        end else if (shift_en) begin
            if (sense != drive) begin
                tx_d.busy = 1'b0;
                tx_d.coll = 1'b1;
                tx_d.cnt  = '0;
            end else if (tx_q.cnt == LAST) begin
                tx_d.busy = 1'b0;
                tx_d.done = 1'b1;
                tx_d.cnt  = '0;
            end else begin
                tx_d.sh  = {tx_q.sh[DATA_W-2:0], 1'b0};
                tx_d.cnt = tx_q.cnt + CW'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) tx_q <= '0;
        else        tx_q <= tx_d;
    end

    assign busy      = tx_q.busy;
    assign done      = tx_q.done;
    assign collision = tx_q.coll;

    assert_done_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
        tx_q.done |=> !tx_q.done);
    assert_frame_odd_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_q.busy) |-> (^tx_q.hold) == 1'b1);
    assert_stall_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        tx_q.busy && !shift_en |=> $stable(tx_q.cnt) && $stable(tx_q.sh) && tx_q.busy);
    assert_load_ignored_R6: assert property (@(posedge clk) disable iff (!rst_n)
        tx_q.busy && load && !shift_en |=> $stable(tx_q.hold));
    assert_coll_stops_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_q.coll) |-> !tx_q.busy && !tx_q.done);
endmodule

// File: rtl/serial_pkt_xcvr.sv
module serial_pkt_xcvr #(
    parameter int DATA_W = pkt_pkg::PKT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              shift_en,
    input  logic              rx_din,
    output logic [DATA_W-1:0] rx_word,
    output logic              rx_parity_err,
    output logic              rx_valid,
    input  logic              tx_load,
    input  logic [DATA_W-1:0] tx_data,
    output logic              tx_drive,
    input  logic              tx_sense,
    output logic              tx_busy,
    output logic              tx_done,
    output logic              tx_collision
);
    pkt_rx #(.DATA_W(DATA_W)) u_rx (
        .clk        (clk),
        .rst_n      (rst_n),
        .shift_en   (shift_en),
        .din        (rx_din),
        .word       (rx_word),
        .parity_err (rx_parity_err),
        .valid      (rx_valid)
    );

    pkt_tx #(.DATA_W(DATA_W)) u_tx (
        .clk        (clk),
        .rst_n      (rst_n),
        .shift_en   (shift_en),
        .load       (tx_load),
        .data       (tx_data),
        .sense      (tx_sense),
        .drive      (tx_drive),
        .busy       (tx_busy),
        .done       (tx_done),
        .collision  (tx_collision)
    );
endmodule

// File: tb/sim_serial_pkt_xcvr.sv
module sim_serial_pkt_xcvr;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        shift_en = 1'b0;
    logic        tx_load = 1'b0;
    logic [15:0] tx_data = '0;
    logic        pull = 1'b1;
    logic        use_bench_src = 1'b0;
    logic        bench_bit = 1'b1;
    logic [15:0] rx_word;
    logic        rx_parity_err, rx_valid, tx_drive, tx_busy, tx_done, tx_collision;
    logic        line, rx_din;
    int          n_cmp = 0;
    int          n_bad = 0;
    bit          finished = 1'b0;

    always #2 clk = ~clk;

    assign line   = tx_drive & pull;
    assign rx_din = use_bench_src ? bench_bit : line;

    serial_pkt_xcvr u0 (
        .clk(clk), .rst_n(rst_n), .shift_en(shift_en), .rx_din(rx_din),
        .rx_word(rx_word), .rx_parity_err(rx_parity_err), .rx_valid(rx_valid),
        .tx_load(tx_load), .tx_data(tx_data), .tx_drive(tx_drive), .tx_sense(line),
        .tx_busy(tx_busy), .tx_done(tx_done), .tx_collision(tx_collision)
    );

    function automatic logic odd_par(input logic [15:0] w);
        return ~^w;
    endfunction

    function automatic logic frame_bit(input logic [15:0] w, input int idx);
        return (idx < 16) ? w[15-idx] : odd_par(w);
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // send one word through the loopback and check both halves
    task automatic tx_send(input logic [15:0] w, input int en_pct);
        int sent = 0;
        @(negedge clk);
        tx_data = w; tx_load = 1'b1; shift_en = 1'b0;
        @(negedge clk);
        tx_load = 1'b0;
        chk("R2 busy after load", 32'(tx_busy), 32'd1);
        chk("R7 collision cleared by load", 32'(tx_collision), 32'd0);
        while (sent < 17) begin
            chk("R2 bit order", 32'(tx_drive), 32'(frame_bit(w, sent)));
            tx_load  = ($urandom % 4) == 0;   // R6: loads while busy
            tx_data  = ~w;
            shift_en = ($urandom % 100) < en_pct;
            @(posedge clk);
            if (shift_en) sent++;
            @(negedge clk);
        end
        tx_load = 1'b0; shift_en = 1'b0;
        chk("R5 busy low", 32'(tx_busy), 32'd0);
        chk("R5 done high", 32'(tx_done), 32'd1);
        chk("R7 no collision", 32'(tx_collision), 32'd0);
        chk("R2 released", 32'(tx_drive), 32'd1);
        @(negedge clk);
        chk("R5 done one cycle", 32'(tx_done), 32'd0);
        chk("R8 valid", 32'(rx_valid), 32'd1);
        chk("R8 word", 32'(rx_word), 32'(w));
        chk("R9 R3 parity good", 32'(rx_parity_err), 32'd0);
        @(negedge clk);
        chk("R8 valid one cycle", 32'(rx_valid), 32'd0);
    endtask

    // feed a frame from the bench, optionally flipping one bit (17 = none)
    task automatic rx_inject(input logic [15:0] w, input int flip);
        logic [15:0] exp_w = w;
        if (flip < 16) exp_w[15-flip] = ~exp_w[15-flip];
        use_bench_src = 1'b1;
        for (int i = 0; i < 17; i++) begin
            bit taken = 1'b0;
            while (!taken) begin
                @(negedge clk);
                bench_bit = frame_bit(w, i) ^ (i == flip);
                shift_en  = ($urandom % 100) < 70;
                @(posedge clk);
                taken = shift_en;
            end
        end
        @(negedge clk);
        shift_en = 1'b0;
        chk("R8 no early valid", 32'(rx_valid), 32'd0);
        @(negedge clk);
        chk("R8 inject valid", 32'(rx_valid), 32'd1);
        chk("R8 inject word", 32'(rx_word), 32'(exp_w));
        chk("R9 inject parity", 32'(rx_parity_err), 32'(flip != 17));
        repeat (3) @(negedge clk);
        chk("R10 word held", 32'(rx_word), 32'(exp_w));
        chk("R10 flag held", 32'(rx_parity_err), 32'(flip != 17));
        use_bench_src = 1'b0;
    endtask

    initial begin
        #(4 * 150000);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 busy", 32'(tx_busy), 32'd0);
        chk("R1 done", 32'(tx_done), 32'd0);
        chk("R1 collision", 32'(tx_collision), 32'd0);
        chk("R1 valid", 32'(rx_valid), 32'd0);
        chk("R1 perr", 32'(rx_parity_err), 32'd0);
        chk("R1 word", 32'(rx_word), 32'd0);
        chk("R1 line released", 32'(tx_drive), 32'd1);

        // directed corners, then random words with varying enable density (R4)
        tx_send(16'h0000, 100);
        tx_send(16'hFFFF, 100);
        tx_send(16'h8000, 50);
        tx_send(16'h0001, 30);
        for (int k = 0; k < 30; k++) tx_send(16'($urandom), 20 + int'($urandom % 80));

        // receive path with injected faults
        rx_inject(16'h1234, 17);
        rx_inject(16'h1234, 0);
        rx_inject(16'hBEEF, 16);
        for (int k = 0; k < 10; k++) rx_inject(16'($urandom), int'($urandom % 18));

        // R7: another module holds the line low
        @(negedge clk);
        pull = 1'b0; tx_data = 16'hFFFF; tx_load = 1'b1;
        @(negedge clk);
        tx_load = 1'b0; shift_en = 1'b1;
        @(negedge clk);
        shift_en = 1'b0;
        chk("R7 collision set", 32'(tx_collision), 32'd1);
        chk("R7 busy cleared", 32'(tx_busy), 32'd0);
        chk("R7 line released", 32'(tx_drive), 32'd1);
        chk("R7 no done", 32'(tx_done), 32'd0);
        pull = 1'b1;
        repeat (4) @(negedge clk);
        chk("R7 collision sticky", 32'(tx_collision), 32'd1);
        // realign receiver (one bit was taken during the collision)
        use_bench_src = 1'b1; bench_bit = 1'b1; shift_en = 1'b1;
        repeat (16) @(negedge clk);
        shift_en = 1'b0;
        repeat (3) @(negedge clk);
        use_bench_src = 1'b0;
        tx_send(16'hA5A5, 60);

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule